// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter with Software Requests

This block decides when the processor must be interrupted. It holds the current interrupt priority level (IPL), a 5-bit value where 0 is ordinary execution and 31 is the highest. Requests come from two places. Hardware sources are level-sensitive lines, and each line has a fixed level in the upper half of the range. Software posts requests by setting one pending bit per level in the range 1 to 15. Every cycle the block finds the highest pending level. It raises `irq` only when that level is strictly above the current IPL.

When the processor accepts the interrupt with `int_ack`, the block does three things. It captures the program counter. It captures a status word whose low five bits hold the IPL in force before acceptance. It moves the current IPL to the accepted level. If the accepted level belongs to software, the block clears that level's pending bit. Software may write any new IPL directly. A return-from-interrupt input reloads the IPL from a saved status word in one cycle. Software can therefore defer work to a lower level by posting a request there. That work is presented automatically once the IPL drops below it.

Top module: `ipl_arbiter`

## Requirements
- R1: After reset, `cur_ipl` is 0, `sw_pend` is all zeros and `irq` is low.
- R2: `sw_set_we` with `sw_set_lvl` = n in 1..15 sets bit n of `sw_pend` at the next clock edge. A value of 0 or of 16 and above changes nothing. Bit 0 of `sw_pend` is always 0.
- R3: `irq_lvl` is the highest level with a pending request, or 0 when none is pending. `irq` is high exactly when `irq_lvl` is strictly greater than `cur_ipl`. Requests at or below `cur_ipl` stay pending.
- R4: Hardware line i has the fixed level 16+i, so any asserted hardware line outranks every software request.
- R5: `int_ack` while `irq` is high loads `cur_ipl` with `irq_lvl` at the next edge. In the same edge `saved_pc` takes `pc_in`, and `saved_psw` takes `psw_in` in the upper bits with the previous `cur_ipl` in bits [4:0].
- R6: An accepted software level has its `sw_pend` bit cleared. An accepted hardware level leaves the line alone, since the source holds it. A set of the same level in the same cycle keeps that bit set.
- R7: `int_ack` while `irq` is low changes neither `cur_ipl` nor the saved registers.
- R8: `ipl_we` loads `cur_ipl` with `ipl_wdata` at the next edge, whether the new value is higher or lower. A pending request above the new level drives `irq` high in the cycle right after the write.
- R9: `rei` loads `cur_ipl` with bits [4:0] of `rei_psw` at the next edge.
- R10: When several updates to the level arrive in the same cycle, an accepted interrupt wins over `rei`, and `rei` wins over `ipl_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NUM_HW | Level-sensitive hardware request lines; line i has level 16+i |
| sw_set_we | input | 1 | Post a software request |
| sw_set_lvl | input | 5 | Level of the software request to post |
| ipl_we | input | 1 | Write the current level |
| ipl_wdata | input | 5 | New current level |
| rei | input | 1 | Return from interrupt |
| rei_psw | input | PSW_W+5 | Status word restored on return; bits [4:0] hold the level |
| int_ack | input | 1 | Processor accepts the presented interrupt |
| pc_in | input | PC_W | Program counter to save on acceptance |
| psw_in | input | PSW_W | Status bits, other than the level, to save on acceptance |
| irq | output | 1 | Interrupt presented |
| irq_lvl | output | 5 | Highest pending level |
| cur_ipl | output | 5 | Current interrupt priority level |
| sw_pend | output | 16 | Pending software requests, one bit per level |
| saved_pc | output | PC_W | Program counter captured on acceptance |
| saved_psw | output | PSW_W+5 | Status word captured on acceptance, with the previous level in bits [4:0] |

## Verification
The bench builds the block with NUM_HW=4, PC_W=16 and PSW_W=4. With four hardware lines, levels 16 to 19 have sources and levels 20 to 31 have none. A random IPL write above 19 therefore masks every request, and a write between 16 and 19 splits the hardware lines into those that are presented and those that are held back. The narrow status field leaves space for random values in the captured word, and the low bits of that word can be checked against the previous level after every acceptance.

// File: rtl/ipl_arbiter.sv
module ipl_arbiter #(
  parameter int NUM_HW = 16,
  parameter int PC_W   = 32,
  parameter int PSW_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_HW-1:0]    hw_req,
  input  logic                 sw_set_we,
  input  logic [4:0]           sw_set_lvl,
  input  logic                 ipl_we,
  input  logic [4:0]           ipl_wdata,
  input  logic                 rei,
  input  logic [PSW_W+4:0]     rei_psw,
  input  logic                 int_ack,
  input  logic [PC_W-1:0]      pc_in,
  input  logic [PSW_W-1:0]     psw_in,
  output logic                 irq,
  output logic [4:0]           irq_lvl,
  output logic [4:0]           cur_ipl,
  output logic [15:0]          sw_pend,
  output logic [PC_W-1:0]      saved_pc,
  output logic [PSW_W+4:0]     saved_psw
);
  localparam int LW    = 5;
  localparam int NLVL  = 1 << LW;
  localparam int NSW   = NLVL / 2;

  logic [NSW-1:0]  hw_ext;
  logic [NLVL-1:0] pend;
  logic [LW-1:0]   top;
  logic            take;
  logic [NSW-1:0]  sw_clr, sw_set;

  assign hw_ext = NSW'(hw_req);
  assign pend   = {hw_ext, sw_pend[NSW-1:1], 1'b0};

  always_comb begin
    top = '0;
    for (int i = 1; i < NLVL; i++)
      if (pend[i]) top = LW'(i);
  end

  assign irq_lvl = top;
  assign irq     = top > cur_ipl;
  assign take    = int_ack && irq;
  assign sw_clr  = (take && !top[LW-1]) ? (NSW'(1) << top[LW-2:0]) : '0;
  assign sw_set  = (sw_set_we && !sw_set_lvl[LW-1] && sw_set_lvl != '0)
                   ? (NSW'(1) << sw_set_lvl[LW-2:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ipl   <= '0;
      sw_pend   <= '0;
      saved_pc  <= '0;
      saved_psw <= '0;
    end else begin
      sw_pend <= (sw_pend & ~sw_clr) | sw_set;
      if (take) begin
        cur_ipl   <= top;
        saved_pc  <= pc_in;
        saved_psw <= {psw_in, cur_ipl};
      end else if (rei) begin
        cur_ipl <= rei_psw[LW-1:0];
      end else if (ipl_we) begin
        cur_ipl <= ipl_wdata;
      end
    end
  end

  p_accept_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && irq |=> cur_ipl == $past(irq_lvl) && saved_pc == $past(pc_in)
      && saved_psw[LW-1:0] == $past(cur_ipl));

  p_ignore_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !irq && !rei && !ipl_we |=> $stable(cur_ipl) && $stable(saved_pc));

  p_rei_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rei && !(int_ack && irq) |=> cur_ipl == $past(rei_psw[LW-1:0]));

  p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_we && !rei && !(int_ack && irq) |=> cur_ipl == $past(ipl_wdata));

  p_sw_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_we && sw_set_lvl != 0 && sw_set_lvl < 16 |=> sw_pend[$past(sw_set_lvl[3:0])]);

  p_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n) !sw_pend[0]);

  p_hw_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |hw_req |-> irq_lvl >= 16);
endmodule

// File: tb/test_ipl_arbiter.sv
`timescale 1ns/1ps
module test_ipl_arbiter;
  localparam int NUM_HW = 4;
  localparam int PC_W   = 16;
  localparam int PSW_W  = 4;

  logic clk = 0, rst_n = 0;
  logic [NUM_HW-1:0] hw_req = '0;
  logic sw_set_we = 0, ipl_we = 0, rei = 0, int_ack = 0;
  logic [4:0] sw_set_lvl = '0, ipl_wdata = '0;
  logic [PSW_W+4:0] rei_psw = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic [PSW_W-1:0] psw_in = '0;
  logic irq;
  logic [4:0] irq_lvl, cur_ipl;
  logic [15:0] sw_pend;
  logic [PC_W-1:0] saved_pc;
  logic [PSW_W+4:0] saved_psw;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [4:0] m_ipl = '0;
  logic [15:0] m_sw = '0;
  logic [PC_W-1:0] m_pc = '0;
  logic [PSW_W+4:0] m_psw = '0;

  ipl_arbiter #(.NUM_HW(NUM_HW), .PC_W(PC_W), .PSW_W(PSW_W)) i_ipl_arbiter (
    .clk, .rst_n, .hw_req, .sw_set_we, .sw_set_lvl, .ipl_we, .ipl_wdata,
    .rei, .rei_psw, .int_ack, .pc_in, .psw_in, .irq, .irq_lvl, .cur_ipl,
    .sw_pend, .saved_pc, .saved_psw);

  always #2.5 clk = ~clk;

  function automatic logic [4:0] exp_top(logic [NUM_HW-1:0] hw, logic [15:0] sw);
    logic [4:0] t = '0;
    for (int i = 1; i < 16; i++) if (sw[i]) t = 5'(i);
    for (int i = 0; i < NUM_HW; i++) if (hw[i]) t = 5'(16 + i);
    return t;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic [NUM_HW-1:0] hw, logic swe, logic [4:0] swl,
                      logic iwe, logic [4:0] iwd, logic r, logic [PSW_W+4:0] rp,
                      logic ack, logic [PC_W-1:0] pc, logic [PSW_W-1:0] ps);
    logic [4:0] t;
    logic take;
    hw_req = hw; sw_set_we = swe; sw_set_lvl = swl; ipl_we = iwe; ipl_wdata = iwd;
    rei = r; rei_psw = rp; int_ack = ack; pc_in = pc; psw_in = ps;
    #0.5;
    t = exp_top(hw, m_sw);
    chk("R3/R4 irq_lvl", irq_lvl, t);
    chk("R3 irq", irq, t > m_ipl);
    take = ack && (t > m_ipl);
    if (take) begin
      m_psw = {ps, m_ipl}; m_pc = pc; m_ipl = t;
      if (t < 16) m_sw[t[3:0]] = 1'b0;
    end else if (r) m_ipl = rp[4:0];
    else if (iwe) m_ipl = iwd;
    if (swe && swl != 0 && swl < 16) m_sw[swl[3:0]] = 1'b1;
    @(posedge clk); #0.5;
    chk("R5/R8/R9/R10 cur_ipl", cur_ipl, m_ipl);
    chk("R2/R6 sw_pend", sw_pend, m_sw);
    chk("R5/R7 saved_pc", saved_pc, m_pc);
    chk("R5/R7 saved_psw", saved_psw, m_psw);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    chk("R1 cur_ipl", cur_ipl, 0);
    chk("R1 sw_pend", sw_pend, 0);
    chk("R1 irq", irq, 0);
    @(negedge clk);
    // R2: levels 0 and 20 ignored, 5 posted
    step('0, 1, 5'd0, 0, 0, 0, 0, 0, 0, 0);
    step('0, 1, 5'd20, 0, 0, 0, 0, 0, 0, 0);
    step('0, 1, 5'd5, 0, 0, 0, 0, 0, 0, 0);
    // R3/R8: raise above, post 7, then lower below
    step('0, 0, 0, 1, 5'd10, 0, 0, 0, 0, 0);
    step('0, 1, 5'd7, 0, 0, 0, 0, 0, 0, 0);
    step('0, 0, 0, 1, 5'd3, 0, 0, 0, 0, 0);
    // R7: ack while masked
    step('0, 0, 0, 1, 5'd15, 0, 0, 0, 0, 0);
    step('0, 0, 0, 0, 0, 0, 0, 1, 16'h1111, 4'h3);
    // R10: ack, rei and write together; then rei vs write
    step('0, 0, 0, 1, 5'd2, 0, 0, 0, 0, 0);
    step('0, 0, 0, 1, 5'd9, 1, 9'h01E, 1, 16'hBEEF, 4'hA);
    step('0, 0, 0, 1, 5'd9, 1, 9'h004, 0, 0, 0);
    // R6: ack of level 5 with same-level post
    step('0, 1, 5'd5, 0, 0, 0, 0, 1, 16'h2222, 4'h5);
    // R4: hardware outranks software
    step(4'b0010, 0, 0, 0, 0, 0, 0, 1, 16'h3333, 4'h6);
    for (int k = 0; k < 4000; k++) begin
      logic [NUM_HW-1:0] hw;
      hw = ($urandom_range(0, 7) == 0) ? NUM_HW'($urandom) : '0;
      step(hw,
           $urandom_range(0, 2) == 0, 5'($urandom_range(0, 17)),
           $urandom_range(0, 5) == 0, 5'($urandom),
           $urandom_range(0, 7) == 0, (PSW_W+5)'($urandom),
           $urandom_range(0, 2) == 0, PC_W'($urandom), PSW_W'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule